// File: doc/BRIEF.md
# Indirect Interrupt-Router Register File

This block is the software-visible register front end of an I/O interrupt router. A 32-bit memory-mapped slave port exposes two words. The selector word at offset 0x00 names an internal register. The window word at offset 0x10 reads or writes the register that the selector names. Behind the window are an identifier register, a read-only version word, an arbitration word that mirrors the identifier, and a table of 64-bit redirection entries, one per interrupt pin. Each entry is reached as two 32-bit halves.

The full table is exported in parallel to a delivery engine. The engine reports accepted level-triggered deliveries, and their end-of-interrupt, through per-pin set and clear strobes on the remote-pending bit. Whenever software writes an entry, the block pulses a strobe carrying the pin number, so the engine can re-evaluate that pin. Software can never write the pending bit or the in-flight status bit of an entry. Moving an entry to edge mode drops a stale pending bit.

Top module: `intr_route_regfile`

## Requirements
- R1: An access is honoured only when `bus_size` is 2 (a 32-bit word) and the offset is 0x00 or 0x10. Any other access changes no state, and a read of it returns zero.
- R2: The selector word reads back the full 32-bit value last written to it. Only its low 8 bits choose the internal register.
- R3: A window write to register 0x00 stores the data ANDed with the identifier mask (default 0x0F000000). Register 0x02 reads the same value as register 0x00.
- R4: Register 0x01 reads ((NPINS-1) << 16) | 0x11, which is 0x001F0011 by default. Window writes to 0x01 and 0x02 are dropped.
- R5: Register 0x10+2p is bits [31:0] of entry p, and 0x11+2p is bits [63:32]. The entry layout is: vector [7:0], delivery mode [10:8], destination mode 11, in-flight status 12, polarity 13, remote pending 14, trigger 15 (1 = level), mask 16, destination [63:56].
- R6: Bits 12 and 14 of an entry are never changed by a bus write to either half. They keep their prior values.
- R7: A bus write that leaves an entry with bit 15 at 0 also leaves its bit 14 at 0, even when a set strobe arrives in the same cycle.
- R8: After reset every entry holds 0x0001000000010000, so every pin is masked.
- R9: Register numbers that name nothing, such as 0x03 and 0x10+2*NPINS, read as zero through the window. Writes to them change nothing.
- R10: `rirr_set[p]` sets bit 14 of entry p and `rirr_clr[p]` clears it, one cycle later. When both are high, set wins. Other entries are unaffected.
- R11: The cycle after each window write to an entry, `entry_wr_stb` is high for one cycle and `entry_wr_pin` carries the entry number. No other write raises it.
- R12: Every read request is answered one cycle later with `bus_rvalid` high and the data on `bus_rdata`. `bus_rvalid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | OFS_W (8) | Byte offset within the block |
| bus_size | input | 2 | log2 of the access size in bytes; 2 = 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response, one cycle after the request |
| rirr_set | input | NPINS (32) | Per-pin set strobe for the remote-pending bit |
| rirr_clr | input | NPINS (32) | Per-pin clear strobe for the remote-pending bit |
| entry_cfg | output | NPINS*64 (2048) | All entries; entry p at bits [64p+63:64p] |
| entry_wr_stb | output | 1 | One-cycle pulse after a table write |
| entry_wr_pin | output | PIN_W (5) | Entry number written |

## Verification
Every result of this block is registered once. A write launched on one edge is visible in `entry_cfg` and the write strobe right after that edge. A read answer appears on `bus_rdata` after the edge that takes the request. A set or clear strobe shows in bit 14 after the edge that samples it. The bench changes inputs on the falling edge and samples on the next falling edge, which is exactly one rising edge later. Each check therefore lands in the cycle its result is due. Pending-bit sequences are checked directly on the exported entry and again through a window read.

// File: rtl/irf_pkg.sv
package irf_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ENTRY_W = 64;

  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [7:0] OFS_SELECT = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;

  localparam logic [7:0] REG_IDENT = 8'h00;
  localparam logic [7:0] REG_VERS  = 8'h01;
  localparam logic [7:0] REG_ARBIT = 8'h02;
  localparam logic [7:0] REG_TBL   = 8'h10;

  localparam int unsigned B_INFLIGHT = 12;
  localparam int unsigned B_PENDING  = 14;
  localparam int unsigned B_LEVEL    = 15;

  localparam logic [ENTRY_W-1:0] ENTRY_RST = 64'h0001_0000_0001_0000;
  localparam logic [ENTRY_W-1:0] ENTRY_RO  =
    (64'd1 << B_PENDING) | (64'd1 << B_INFLIGHT);

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_SELECT = 2'd1,
    ACC_WINDOW = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/irf_bus_port.sv
module irf_bus_port
  import irf_pkg::*;
#(
  parameter int unsigned OFS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [WORD_W-1:0] bus_wdata,
  output acc_kind_e         acc_kind,
  output logic [WORD_W-1:0] select_q
);
  logic [WORD_W-1:0] select_n;
  logic              select_en;

  always_comb begin
    acc_kind = ACC_NONE;
    if (bus_valid && (bus_size == SZ_WORD)) begin
      if (bus_addr == OFS_W'(OFS_SELECT))      acc_kind = ACC_SELECT;
      else if (bus_addr == OFS_W'(OFS_WINDOW)) acc_kind = ACC_WINDOW;
    end
  end

  always_comb begin
    select_en = (acc_kind == ACC_SELECT) && bus_write;
    select_n  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         select_q <= '0;
    else if (select_en) select_q <= select_n;
  end

  // R1: a malformed write leaves the selector alone
  p_sel_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && (bus_size != SZ_WORD)) |=> $stable(select_q));
endmodule

// File: rtl/irf_redir_entry.sv
module irf_redir_entry
  import irf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_hi,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               pend_set,
  input  logic               pend_clr,
  output logic [ENTRY_W-1:0] cfg_q
);
  logic [ENTRY_W-1:0] half_mask;
  logic [ENTRY_W-1:0] half_data;
  logic [ENTRY_W-1:0] merged;
  logic [ENTRY_W-1:0] cfg_n;
  logic               pend_n;
  logic               cfg_en;

  always_comb begin
    half_mask = wr_hi ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
    half_data = wr_hi ? {wr_data, 32'h0} : {32'h0, wr_data};
    merged    = (cfg_q & (~half_mask | ENTRY_RO)) | (half_data & half_mask & ~ENTRY_RO);
    cfg_n     = wr_en ? merged : cfg_q;

    if (pend_set)      pend_n = 1'b1;
    else if (pend_clr) pend_n = 1'b0;
    else               pend_n = cfg_q[B_PENDING];
    if (wr_en && !cfg_n[B_LEVEL]) pend_n = 1'b0;

    cfg_n[B_PENDING] = pend_n;
    cfg_en = wr_en | pend_set | pend_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= ENTRY_RST;
    else if (cfg_en) cfg_q <= cfg_n;
  end

  p_edge_no_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q[B_LEVEL] || !cfg_q[B_PENDING]));

  p_write_never_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pend_set && !pend_clr && !cfg_q[B_PENDING]) |=> !cfg_q[B_PENDING]);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set && !wr_en) |=> cfg_q[B_PENDING]);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !pend_set && !wr_en) |=> !cfg_q[B_PENDING]);
endmodule

// File: rtl/irf_read_mux.sv
module irf_read_mux
  import irf_pkg::*;
#(
  parameter int unsigned       NPINS   = 32,
  parameter int unsigned       PIN_W   = 5,
  parameter logic [WORD_W-1:0] VERSION = 32'h001F_0011
) (
  input  acc_kind_e                  acc_kind,
  input  logic [WORD_W-1:0]          select_q,
  input  logic [WORD_W-1:0]          ident_q,
  input  logic [7:0]                 reg_num,
  input  logic                       ent_hit,
  input  logic [PIN_W-1:0]           ent_pin,
  input  logic                       ent_hi,
  input  logic [NPINS*ENTRY_W-1:0]   table_flat,
  output logic [WORD_W-1:0]          rdata_n
);
  logic [WORD_W-1:0] ent_word;

  always_comb begin
    ent_word = '0;
    for (int p = 0; p < NPINS; p++) begin
      if (ent_pin == PIN_W'(p))
        ent_word = ent_hi ? table_flat[p*ENTRY_W+WORD_W +: WORD_W]
                          : table_flat[p*ENTRY_W +: WORD_W];
    end
  end

  always_comb begin
    rdata_n = '0;
    case (acc_kind)
      ACC_SELECT: rdata_n = select_q;
      ACC_WINDOW: begin
        if (ent_hit) rdata_n = ent_word;
        else begin
          case (reg_num)
            REG_IDENT, REG_ARBIT: rdata_n = ident_q;
            REG_VERS:             rdata_n = VERSION;
            default:              rdata_n = '0;
          endcase
        end
      end
      default: rdata_n = '0;
    endcase
  end
endmodule

// File: rtl/intr_route_regfile.sv
module intr_route_regfile
  import irf_pkg::*;
#(
  parameter int unsigned       NPINS      = 32,
  parameter int unsigned       OFS_W      = 8,
  parameter logic [WORD_W-1:0] IDENT_MASK = 32'h0F00_0000,
  localparam int unsigned      PIN_W      = $clog2(NPINS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [OFS_W-1:0]         bus_addr,
  input  logic [1:0]               bus_size,
  input  logic [WORD_W-1:0]        bus_wdata,
  output logic [WORD_W-1:0]        bus_rdata,
  output logic                     bus_rvalid,
  input  logic [NPINS-1:0]         rirr_set,
  input  logic [NPINS-1:0]         rirr_clr,
  output logic [NPINS*ENTRY_W-1:0] entry_cfg,
  output logic                     entry_wr_stb,
  output logic [PIN_W-1:0]         entry_wr_pin
);
  localparam logic [WORD_W-1:0] VERSION = (WORD_W'(NPINS - 1) << 16) | 32'h11;
  localparam logic [8:0]        TBL_END = 9'(REG_TBL) + 9'(2 * NPINS);

  acc_kind_e         acc_kind;
  logic [WORD_W-1:0] select_q;
  logic [WORD_W-1:0] ident_q, ident_n;
  logic              ident_en;
  logic [7:0]        reg_num, tbl_off;
  logic              ent_hit, ent_hi;
  logic [PIN_W-1:0]  ent_pin;
  logic              win_wr, rd_req, tbl_wr;
  logic [WORD_W-1:0] rdata_n;

  irf_bus_port #(.OFS_W(OFS_W)) u_port (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .acc_kind(acc_kind), .select_q(select_q)
  );

  always_comb begin
    reg_num  = select_q[7:0];
    tbl_off  = reg_num - REG_TBL;
    ent_hit  = (reg_num >= REG_TBL) && ({1'b0, reg_num} < TBL_END);
    ent_pin  = PIN_W'(tbl_off >> 1);
    ent_hi   = tbl_off[0];
    win_wr   = (acc_kind == ACC_WINDOW) && bus_write;
    rd_req   = bus_valid && !bus_write;
    tbl_wr   = win_wr && ent_hit;
    ident_en = win_wr && (reg_num == REG_IDENT);
    ident_n  = bus_wdata & IDENT_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ident_q <= '0;
    else if (ident_en) ident_q <= ident_n;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_entry
    logic this_wr;
    assign this_wr = tbl_wr && (ent_pin == PIN_W'(p));
    irf_redir_entry u_entry (
      .clk(clk), .rst_n(rst_n), .wr_en(this_wr), .wr_hi(ent_hi),
      .wr_data(bus_wdata), .pend_set(rirr_set[p]), .pend_clr(rirr_clr[p]),
      .cfg_q(entry_cfg[p*ENTRY_W +: ENTRY_W])
    );
  end

  irf_read_mux #(.NPINS(NPINS), .PIN_W(PIN_W), .VERSION(VERSION)) u_rmux (
    .acc_kind(acc_kind), .select_q(select_q), .ident_q(ident_q),
    .reg_num(reg_num), .ent_hit(ent_hit), .ent_pin(ent_pin), .ent_hi(ent_hi),
    .table_flat(entry_cfg), .rdata_n(rdata_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid   <= 1'b0;
      entry_wr_stb <= 1'b0;
    end else begin
      bus_rvalid   <= rd_req;
      entry_wr_stb <= tbl_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rdata_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      entry_wr_pin <= '0;
    else if (tbl_wr) entry_wr_pin <= ent_pin;
  end

  p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);

  p_rvalid_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);

  p_stray_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (acc_kind == ACC_NONE)) |=> (bus_rdata == '0));

  p_version_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (acc_kind == ACC_WINDOW) && (reg_num == REG_VERS)) |=> (bus_rdata == VERSION));

  p_wr_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr |=> (entry_wr_stb && (entry_wr_pin == $past(ent_pin))));

  p_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_wr |=> !entry_wr_stb);
endmodule

// File: tb/sim_intr_route_regfile.sv
`timescale 1ns/1ps
module sim_intr_route_regfile;
  localparam int NPINS = 32;
  localparam int PIN_W = 5;
  localparam int NVEC  = 38;

  typedef struct packed {
    logic        rd;
    logic [7:0]  ofs;
    logic [1:0]  sz;
    logic [31:0] dat;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // vectors: writes carry no expectation; reads compare bus_rdata
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 8'h00, 2'd2, 32'h0000_0000, 32'h0, 4'd3},  // R3 select ident
    '{1'b0, 8'h10, 2'd2, 32'hFFFF_FFFF, 32'h0, 4'd3},
    '{1'b1, 8'h10, 2'd2, 32'h0, 32'h0F00_0000, 4'd3},  // R3 masked store
    '{1'b0, 8'h00, 2'd2, 32'h0000_0002, 32'h0, 4'd3},
    '{1'b1, 8'h10, 2'd2, 32'h0, 32'h0F00_0000, 4'd3},  // R3 mirror
    '{1'b0, 8'h10, 2'd2, 32'h0000_0000, 32'h0, 4'd4},  // R4 dropped write
    '{1'b1, 8'h10, 2'd2, 32'h0, 32'h0F00_0000, 4'd4},
    '{1'b0, 8'h00, 2'd2, 32'h0000_0001, 32'h0, 4'd4},
    '{1'b1, 8'h10, 2'd2, 32'h0, 32'h001F_0011, 4'd4},  // R4 version
    '{1'b0, 8'h10, 2'd2, 32'h1234_5678, 32'h0, 4'd4},
    '{1'b1, 8'h10, 2'd2, 32'h0, 32'h001F_0011, 4'd4},
    '{1'b0, 8'h00, 2'd2, 32'h0000_0110, 32'h0, 4'd2},  // R2 upper bits ignored
    '{1'b1, 8'h00, 2'd2, 32'h0, 32'h0000_0110, 4'd2},  // R2 readback
    '{1'b1, 8'h10, 2'd2, 32'h0, 32'h0001_0000, 4'd8},  // R8 entry 0 low
    '{1'b0, 8'h10, 2'd2, 32'hFFFF_FFFF, 32'h0, 4'd6},
    '{1'b1, 8'h10, 2'd2, 32'h0, 32'hFFFF_AFFF, 4'd6},  // R6 read-only bits
    '{1'b0, 8'h00, 2'd2, 32'h0000_003F, 32'h0, 4'd5},
    '{1'b1, 8'h10, 2'd2, 32'h0, 32'h0001_0000, 4'd8},  // R8 entry 23 high
    '{1'b0, 8'h10, 2'd2, 32'hAB00_0000, 32'h0, 4'd5},
    '{1'b1, 8'h10, 2'd2, 32'h0, 32'hAB00_0000, 4'd5},  // R5 high half
    '{1'b0, 8'h00, 2'd2, 32'h0000_003E, 32'h0, 4'd5},
    '{1'b1, 8'h10, 2'd2, 32'h0, 32'h0001_0000, 4'd5},  // R5 low half untouched
    '{1'b0, 8'h04, 2'd2, 32'h0000_0055, 32'h0, 4'd1},  // R1 bad offset
    '{1'b1, 8'h04, 2'd2, 32'h0, 32'h0000_0000, 4'd1},
    '{1'b1, 8'h00, 2'd2, 32'h0, 32'h0000_003E, 4'd1},
    '{1'b0, 8'h00, 2'd0, 32'h0000_0000, 32'h0, 4'd1},  // R1 byte write
    '{1'b1, 8'h00, 2'd2, 32'h0, 32'h0000_003E, 4'd1},
    '{1'b1, 8'h00, 2'd1, 32'h0, 32'h0000_0000, 4'd1},  // R1 half read
    '{1'b1, 8'h10, 2'd3, 32'h0, 32'h0000_0000, 4'd1},  // R1 wide read
    '{1'b0, 8'h00, 2'd2, 32'h0000_0050, 32'h0, 4'd9},  // R9 past the table
    '{1'b0, 8'h10, 2'd2, 32'hFFFF_FFFF, 32'h0, 4'd9},
    '{1'b1, 8'h10, 2'd2, 32'h0, 32'h0000_0000, 4'd9},
    '{1'b0, 8'h00, 2'd2, 32'h0000_0003, 32'h0, 4'd9},
    '{1'b1, 8'h10, 2'd2, 32'h0, 32'h0000_0000, 4'd9},
    '{1'b0, 8'h00, 2'd2, 32'h0000_0000, 32'h0, 4'd9},
    '{1'b1, 8'h10, 2'd2, 32'h0, 32'h0F00_0000, 4'd9},  // R9 ident untouched
    '{1'b0, 8'h00, 2'd2, 32'h0000_004F, 32'h0, 4'd8},
    '{1'b1, 8'h10, 2'd2, 32'h0, 32'h0001_0000, 4'd8}   // R8 entry 31 high
  };

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   bus_valid, bus_write;
  logic [7:0]             bus_addr;
  logic [1:0]             bus_size;
  logic [31:0]            bus_wdata, bus_rdata;
  logic                   bus_rvalid;
  logic [NPINS-1:0]       rirr_set, rirr_clr;
  logic [NPINS*64-1:0]    entry_cfg;
  logic                   entry_wr_stb;
  logic [PIN_W-1:0]       entry_wr_pin;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  intr_route_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .rirr_set(rirr_set),
    .rirr_clr(rirr_clr), .entry_cfg(entry_cfg), .entry_wr_stb(entry_wr_stb),
    .entry_wr_pin(entry_wr_pin)
  );

  function automatic logic [63:0] ent(input int p);
    return entry_cfg[p*64 +: 64];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] ofs, input logic [1:0] sz, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = ofs; bus_size = sz; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] ofs, input logic [1:0] sz,
                        output logic [31:0] d, output logic v);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = ofs; bus_size = sz;
    @(posedge clk); @(negedge clk);
    d = bus_rdata; v = bus_rvalid;
    bus_valid = 1'b0;
  endtask

  task automatic strobe(input logic [NPINS-1:0] s, input logic [NPINS-1:0] c);
    rirr_set = s; rirr_clr = c;
    @(posedge clk); @(negedge clk);
    rirr_set = '0; rirr_clr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        rv;
    logic        all_rst;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
    bus_size = '0; bus_wdata = '0; rirr_set = '0; rirr_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state of the whole table and the outputs
    all_rst = 1'b1;
    for (int p = 0; p < NPINS; p++)
      if (ent(p) !== 64'h0001_0000_0001_0000) all_rst = 1'b0;
    chk("R8 all entries", 64'(all_rst), 64'd1);
    chk("R12 rvalid at reset", 64'(bus_rvalid), 64'd0);
    chk("R11 strobe at reset", 64'(entry_wr_stb), 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].rd) begin
        bus_rd(VEC[i].ofs, VEC[i].sz, rd, rv);
        checks++;
        if (rd !== VEC[i].exp) begin
          errors++;
          $display("FAIL R%0d vector %0d: actual %h expected %h", VEC[i].req, i, rd, VEC[i].exp);
        end
      end else begin
        bus_wr(VEC[i].ofs, VEC[i].sz, VEC[i].dat);
      end
    end

    // R12 response timing
    bus_rd(8'h00, 2'd2, rd, rv);
    chk("R12 rvalid one cycle later", 64'(rv), 64'd1);
    @(negedge clk);
    chk("R12 rvalid drops", 64'(bus_rvalid), 64'd0);

    // R11 entry-written strobe
    bus_wr(8'h00, 2'd2, 32'h12);
    chk("R11 no strobe for selector write", 64'(entry_wr_stb), 64'd0);
    bus_wr(8'h10, 2'd2, 32'h0000_00C5);
    chk("R11 strobe high", 64'(entry_wr_stb), 64'd1);
    chk("R11 strobe pin", 64'(entry_wr_pin), 64'd1);
    chk("R5 entry 1 low", ent(1), 64'h0001_0000_0000_00C5);
    @(negedge clk);
    chk("R11 strobe one cycle", 64'(entry_wr_stb), 64'd0);

    // R10 / R6 / R7 pending bit on entry 2
    bus_wr(8'h00, 2'd2, 32'h14);
    bus_wr(8'h10, 2'd2, 32'h0000_A030);
    chk("R5 entry 2 level", ent(2), 64'h0001_0000_0000_A030);
    strobe(32'h4, 32'h0);
    chk("R10 set", ent(2), 64'h0001_0000_0000_E030);
    chk("R10 neighbour untouched", ent(3), 64'h0001_0000_0001_0000);
    bus_wr(8'h10, 2'd2, 32'h0000_A031);
    chk("R6 pending kept on low write", ent(2), 64'h0001_0000_0000_E031);
    bus_rd(8'h10, 2'd2, rd, rv);
    chk("R6 window shows pending", 64'(rd), 64'h0000_E031);
    bus_wr(8'h00, 2'd2, 32'h15);
    bus_wr(8'h10, 2'd2, 32'hFF00_0000);
    chk("R6 pending kept on high write", ent(2), 64'hFF00_0000_0000_E031);
    bus_wr(8'h00, 2'd2, 32'h14);
    bus_wr(8'h10, 2'd2, 32'h0000_2031);
    chk("R7 edge clears pending", ent(2), 64'hFF00_0000_0000_2031);
    bus_wr(8'h10, 2'd2, 32'h0000_E031);
    chk("R6 write cannot set pending", ent(2), 64'hFF00_0000_0000_A031);
    strobe(32'h4, 32'h0);
    strobe(32'h0, 32'h4);
    chk("R10 clear", ent(2), 64'hFF00_0000_0000_A031);
    strobe(32'h4, 32'h4);
    chk("R10 set wins", ent(2), 64'hFF00_0000_0000_E031);
    rirr_set = 32'h4;
    bus_wr(8'h10, 2'd2, 32'h0000_2031);
    rirr_set = '0;
    chk("R7 edge write beats set", ent(2), 64'hFF00_0000_0000_2031);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule